// File: doc/BRIEF.md
# Event-Driven Proposition State Identifier

This block sits between a monitor register file and a temporal-logic checker. Software running on a processor signals that something happened by flipping one bit of an event register. The register file also holds two monitored data words and raises a write strobe whenever software writes to it. From these inputs the block produces the one-bit atomic propositions that the checker evaluates on every clock.

Three kinds of logic produce the propositions. Toggle detectors keep the previous value of each event bit in a single flop. A detector pulses for exactly one cycle when the current value differs from the stored value. Two of these pulses drive the consumer-side propositions `read_start` and `read_end`. Three other pulses drive a three-state Moore machine. That machine follows a producer, a middle task and two buffers between them, and reports on `synchro` whether the second buffer still holds a result computed from the current content of the first buffer. A registered comparator checks a monitored word against a second monitored word or against a constant, and refreshes its result on each write strobe.

Software cannot write twice on consecutive cycles, because every bus write takes at least two cycles. For that reason, one flop per event bit is enough to detect every event.

Top module: `prop_state_identifier`

## Requirements
- R1: During and right after a synchronous active-high reset, `synchro` is 1, `read_start`, `read_end` and `cmp_hit` are 0, and all toggle-detector flops are 0.
- R2: `read_start` is 1 in exactly those cycles where `evt_reg[3]` (consumer reads its first input) differs from its value one clock earlier. Both the 0-to-1 and the 1-to-0 change count as events.
- R3: `read_end` is 1 in exactly those cycles where `evt_reg[4]` (consumer reads its second input) differs from its value one clock earlier.
- R4: In the coherent state, a change of `evt_reg[0]` (producer writes buffer 0) makes `synchro` 0 from the next clock.
- R5: In the awaiting-read state, a change of `evt_reg[1]` (middle task reads buffer 0) moves the machine to the awaiting-write state. A further change of `evt_reg[0]` keeps it awaiting a read. A change of `evt_reg[2]` is ignored. `synchro` stays 0 in all three cases.
- R6: In the awaiting-write state, a change of `evt_reg[2]` (middle task writes buffer 1) makes `synchro` 1 from the next clock. A change of `evt_reg[0]` instead returns the machine to awaiting a read, and that change takes priority when both bits change together.
- R7: Events with no transition from the current state leave `synchro` unchanged. Examples are `evt_reg[1]` or `evt_reg[2]` while coherent, and `evt_reg[3]` or `evt_reg[4]` in any state.
- R8: On each clock with `wr_stb` high, `cmp_hit` becomes the unsigned comparison (default: less than) of `cmp_a` against the operand. The operand is `cmp_b`, or a constant when the constant-operand parameter is set. On clocks with `wr_stb` low, `cmp_hit` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Register-file write strobe; updates the comparator result |
| evt_reg | input | 5 | Software event bits: 0 producer writes buffer 0, 1 middle task reads buffer 0, 2 middle task writes buffer 1, 3 consumer reads its first input, 4 consumer reads its second input |
| cmp_a | input | DATA_W | Monitored word, left operand of the comparator |
| cmp_b | input | DATA_W | Monitored word, right operand when no constant is selected |
| synchro | output | 1 | Buffer-coherence proposition (Moore output) |
| read_start | output | 1 | One-cycle pulse when the consumer reads its first input |
| read_end | output | 1 | One-cycle pulse when the consumer reads its second input |
| cmp_hit | output | 1 | Registered comparator proposition |

## Verification
A wrong coherence state does not show up at the ports until an event arrives. The fault then appears as a `synchro` level that differs from the reference, one clock after the event pulse that should have moved the machine. The bench therefore steps through every row of the transition table and then runs long mixed event sequences, so that a stuck or misrouted state is caught on the next qualifying event. A corrupted delay flop shows up within the same cycle as a missing or extra pulse on `read_start` or `read_end`. A wrong comparator result shows up one clock after a strobe.

// File: rtl/psi_pkg.sv
package psi_pkg;

  // Bit positions in the event register (the toggle detectors decode these).
  localparam int unsigned EV_PROD_WR   = 0;
  localparam int unsigned EV_MID_RD    = 1;
  localparam int unsigned EV_MID_WR    = 2;
  localparam int unsigned EV_RD_FIRST  = 3;
  localparam int unsigned EV_RD_SECOND = 4;
  localparam int unsigned EV_COUNT     = 5;

  typedef enum logic [1:0] {
    ST_COHERENT    = 2'd0,
    ST_AWAIT_READ  = 2'd1,
    ST_AWAIT_WRITE = 2'd2
  } sync_state_e;

  typedef enum logic [1:0] {
    CMP_EQ = 2'd0,
    CMP_NE = 2'd1,
    CMP_LT = 2'd2,
    CMP_GE = 2'd3
  } cmp_op_e;

endpackage

// File: rtl/toggle_detect.sv
module toggle_detect #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level_in,
  output logic [WIDTH-1:0] pulse_out
);

  // One delay flop per event bit; a pulse marks any difference.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic held_q;

    always_ff @(posedge clk) begin
      if (rst) held_q <= 1'b0;
      else     held_q <= level_in[i];
    end

    assign pulse_out[i] = level_in[i] ^ held_q;
  end

endmodule

// File: rtl/operand_compare.sv
module operand_compare
  import psi_pkg::*;
#(
  parameter int unsigned      DATA_W    = 8,
  parameter cmp_op_e          OP        = CMP_LT,
  parameter bit               USE_CONST = 1'b0,
  parameter logic [DATA_W-1:0] CONST_VAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              hit
);

  logic [DATA_W-1:0] rhs;
  logic              result;

  if (USE_CONST) begin : g_const
    assign rhs = CONST_VAL;
  end else begin : g_reg
    assign rhs = opnd_b;
  end

  always_comb begin
    unique case (OP)
      CMP_EQ:  result = (opnd_a == rhs);
      CMP_NE:  result = (opnd_a != rhs);
      CMP_LT:  result = (opnd_a <  rhs);
      default: result = (opnd_a >= rhs);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)      hit <= 1'b0;
    else if (upd) hit <= result;
  end

endmodule

// File: rtl/coherence_fsm.sv
module coherence_fsm
  import psi_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ev_prod_wr,
  input  logic ev_mid_rd,
  input  logic ev_mid_wr,
  output logic coherent
);

  sync_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_COHERENT: begin
        if (ev_prod_wr) state_d = ST_AWAIT_READ;
      end
      ST_AWAIT_READ: begin
        if (ev_mid_rd && !ev_prod_wr) state_d = ST_AWAIT_WRITE;
      end
      ST_AWAIT_WRITE: begin
        if (ev_prod_wr)     state_d = ST_AWAIT_READ;
        else if (ev_mid_wr) state_d = ST_COHERENT;
      end
      default: state_d = ST_COHERENT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_COHERENT;
      coherent <= 1'b1;
    end else begin
      state_q  <= state_d;
      coherent <= (state_d == ST_COHERENT);
    end
  end

endmodule

// File: rtl/prop_state_identifier.sv
module prop_state_identifier
  import psi_pkg::*;
#(
  parameter int unsigned       DATA_W        = 8,
  parameter cmp_op_e           CMP_OP        = CMP_LT,
  parameter bit                CMP_USE_CONST = 1'b0,
  parameter logic [DATA_W-1:0] CMP_CONST     = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [4:0]        evt_reg,
  input  logic [DATA_W-1:0] cmp_a,
  input  logic [DATA_W-1:0] cmp_b,
  output logic              synchro,
  output logic              read_start,
  output logic              read_end,
  output logic              cmp_hit
);

  localparam int unsigned EW = EV_COUNT;

  logic [EW-1:0] evt_pulse;

  toggle_detect #(.WIDTH(EW)) u_detect (
    .clk       (clk),
    .rst       (rst),
    .level_in  (evt_reg),
    .pulse_out (evt_pulse)
  );

  coherence_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .ev_prod_wr (evt_pulse[EV_PROD_WR]),
    .ev_mid_rd  (evt_pulse[EV_MID_RD]),
    .ev_mid_wr  (evt_pulse[EV_MID_WR]),
    .coherent   (synchro)
  );

  operand_compare #(
    .DATA_W    (DATA_W),
    .OP        (CMP_OP),
    .USE_CONST (CMP_USE_CONST),
    .CONST_VAL (CMP_CONST)
  ) u_cmp (
    .clk    (clk),
    .rst    (rst),
    .upd    (wr_stb),
    .opnd_a (cmp_a),
    .opnd_b (cmp_b),
    .hit    (cmp_hit)
  );

  assign read_start = evt_pulse[EV_RD_FIRST];
  assign read_end   = evt_pulse[EV_RD_SECOND];

endmodule

// File: rtl/psi_checker.sv
module psi_checker (
  input logic       clk,
  input logic       rst,
  input logic       wr_stb,
  input logic [4:0] evt_reg,
  input logic [4:0] evt_pulse,
  input logic       synchro,
  input logic       read_start,
  input logic       read_end,
  input logic       cmp_hit
);

  assert_reset_coherent_R1: assert property (@(posedge clk)
    rst |=> (synchro && !cmp_hit));

  assert_start_on_change_R2: assert property (@(posedge clk) disable iff (rst)
    (read_start && !$past(rst)) |-> (evt_reg[3] != $past(evt_reg[3])));

  assert_end_on_change_R3: assert property (@(posedge clk) disable iff (rst)
    (read_end && !$past(rst)) |-> (evt_reg[4] != $past(evt_reg[4])));

  assert_drop_needs_prod_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(synchro)) |-> $past(evt_pulse[0]));

  assert_rise_needs_midwr_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(synchro)) |-> $past(evt_pulse[2] && !evt_pulse[0]));

  assert_hold_no_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(wr_stb)) |-> $stable(cmp_hit));

endmodule

bind prop_state_identifier psi_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_stb     (wr_stb),
  .evt_reg    (evt_reg),
  .evt_pulse  (evt_pulse),
  .synchro    (synchro),
  .read_start (read_start),
  .read_end   (read_end),
  .cmp_hit    (cmp_hit)
);

// File: tb/sim_prop_state_identifier.sv
module sim_prop_state_identifier;
  import psi_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam logic [DW-1:0] KVAL = 8'd100;
  localparam int WATCHDOG   = 20000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_stb = 1'b0;
  logic [4:0]    evt_reg = '0;
  logic [DW-1:0] cmp_a = '0;
  logic [DW-1:0] cmp_b = '0;
  logic synchro, read_start, read_end, cmp_hit;
  logic synchro1, read_start1, read_end1, cmp_hit1;

  int total = 0;
  int bad = 0;
  bit checking = 1'b0;
  string cur_tag = "R1";

  // reference model state
  logic [4:0] m_prev = '0;
  int         m_state = 0;   // 0 coherent, 1 awaiting read, 2 awaiting write
  bit         m_cmp = 1'b0;
  bit         m_cmp1 = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prop_state_identifier u0 (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .evt_reg(evt_reg),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .synchro(synchro),
    .read_start(read_start), .read_end(read_end), .cmp_hit(cmp_hit)
  );

  prop_state_identifier #(.CMP_USE_CONST(1'b1), .CMP_CONST(KVAL)) u1 (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .evt_reg(evt_reg),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .synchro(synchro1),
    .read_start(read_start1), .read_end(read_end1), .cmp_hit(cmp_hit1)
  );

  always @(posedge clk) begin
    logic [4:0] p;
    if (rst) begin
      m_prev  <= '0;
      m_state <= 0;
      m_cmp   <= 1'b0;
      m_cmp1  <= 1'b0;
    end else begin
      p = evt_reg ^ m_prev;
      m_prev <= evt_reg;
      if (m_state == 0 && p[0])      m_state <= 1;
      else if (m_state == 1 && p[0]) m_state <= 1;
      else if (m_state == 1 && p[1]) m_state <= 2;
      else if (m_state == 2 && p[0]) m_state <= 1;
      else if (m_state == 2 && p[2]) m_state <= 0;
      if (wr_stb) begin
        m_cmp  <= (cmp_a < cmp_b);
        m_cmp1 <= (cmp_a < KVAL);
      end
    end
  end

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      logic [4:0] p;
      p = evt_reg ^ m_prev;
      check("R2", "read_start", read_start, p[3]);
      check("R3", "read_end", read_end, p[4]);
      check(cur_tag, "synchro", synchro, m_state == 0);
      check("R8", "cmp_hit(reg)", cmp_hit, m_cmp);
      check("R8", "cmp_hit(const)", cmp_hit1, m_cmp1);
      check(cur_tag, "synchro(u1)", synchro1, m_state == 0);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      wr_stb = 1'b0;
    end
  endtask

  // Toggle one event bit, then leave at least one quiet cycle.
  task automatic fire(input int idx, input string tag);
    cur_tag = tag;
    @(posedge clk); #1;
    evt_reg[idx] = ~evt_reg[idx];
    idle(2);
  endtask

  task automatic strobe(input logic [DW-1:0] a, input logic [DW-1:0] b, input bit s);
    cur_tag = "R8";
    @(posedge clk); #1;
    cmp_a = a; cmp_b = b; wr_stb = s;
    @(posedge clk); #1;
    wr_stb = 1'b0;
  endtask

  task automatic run();
    // R1: reset values, checked directly while reset is held
    idle(3);
    @(negedge clk);
    check("R1", "synchro in reset", synchro, 1'b1);
    check("R1", "read_start in reset", read_start, 1'b0);
    check("R1", "read_end in reset", read_end, 1'b0);
    check("R1", "cmp_hit in reset", cmp_hit, 1'b0);
    @(posedge clk); #1;
    rst = 1'b0;
    checking = 1'b1;
    idle(2);

    // R7: events with no transition while coherent
    fire(EV_MID_RD, "R7");
    fire(EV_MID_WR, "R7");
    fire(EV_RD_FIRST, "R7");
    fire(EV_RD_SECOND, "R7");
    // R4
    fire(EV_PROD_WR, "R4");
    // R5
    fire(EV_MID_WR, "R5");
    fire(EV_PROD_WR, "R5");
    fire(EV_RD_FIRST, "R7");
    fire(EV_MID_RD, "R5");
    // R6: prod write in awaiting-write returns to awaiting-read
    fire(EV_PROD_WR, "R6");
    fire(EV_MID_WR, "R6");
    fire(EV_MID_RD, "R6");
    fire(EV_RD_SECOND, "R7");
    fire(EV_MID_WR, "R6");
    // R6: simultaneous prod write and mid write in awaiting-write
    fire(EV_PROD_WR, "R4");
    fire(EV_MID_RD, "R5");
    cur_tag = "R6";
    @(posedge clk); #1;
    evt_reg[EV_PROD_WR] = ~evt_reg[EV_PROD_WR];
    evt_reg[EV_MID_WR]  = ~evt_reg[EV_MID_WR];
    idle(2);
    fire(EV_MID_RD, "R5");
    fire(EV_MID_WR, "R6");

    // R2, R3: both toggle directions already covered; repeat back to back gaps
    fire(EV_RD_FIRST, "R2");
    fire(EV_RD_SECOND, "R3");

    // R8: comparator with and without strobe
    strobe(8'd5, 8'd9, 1'b1);
    strobe(8'd200, 8'd9, 1'b0);
    idle(1);
    strobe(8'd9, 8'd9, 1'b1);
    strobe(8'd99, 8'd0, 1'b1);
    strobe(8'd100, 8'd255, 1'b1);
    strobe(8'd0, 8'd1, 1'b0);
    idle(2);

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int r;
      r = $urandom_range(0, 7);
      cur_tag = "R4";
      @(posedge clk); #1;
      if (r < 5) evt_reg[r] = ~evt_reg[r];
      cmp_a  = 8'($urandom);
      cmp_b  = 8'($urandom);
      wr_stb = ($urandom_range(0, 2) == 0);
      @(posedge clk); #1;
      wr_stb = 1'b0;
    end
    idle(3);

    // R1: reset again from a non-coherent state
    fire(EV_PROD_WR, "R4");
    @(posedge clk); #1;
    checking = 1'b0;
    rst = 1'b1;
    evt_reg = '0;
    @(posedge clk); #1;
    @(negedge clk);
    check("R1", "synchro after re-reset", synchro, 1'b1);
    check("R1", "cmp_hit after re-reset", cmp_hit, 1'b0);
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check("R1", "read_start after reset", read_start, 1'b0);
    check("R1", "synchro out of reset", synchro, 1'b1);
  endtask

  initial begin
    fork
      run();
      begin
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule